// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit linear address into a 32-bit physical address by reading translation entries from memory. A request carries the linear address. The walker combines it with the page-directory base and a large-page enable, both captured when the request is accepted. It then fetches a directory entry and, for a small (4 KiB) page, a table entry after it. When large pages are enabled and the directory entry carries its size flag, the walk stops after one read and maps a 4 MiB page.

Memory is reached through a simple read port that has one read in flight at a time: an address with a valid/ready handshake, then a single-cycle read-data strobe. The result is held on a valid/ready response port until the consumer takes it. It carries the physical address, a fault flag, the level of the last entry read, and a large-page indicator. A new request is taken only while the walker is idle.

Top module: `pgw_walker`

## Requirements
- R1: After reset, `req_ready` is 1 and both `mem_valid` and `rsp_valid` are 0.
- R2: The first read of every walk uses address {dir_base[31:12], laddr[31:22], 2'b00}, where dir_base is the value captured at acceptance.
- R3: When a table read is made, its address is {dentry[31:12], laddr[21:12], 2'b00}, where dentry is the directory entry just read.
- R4: For a small page with both entries present (bit 0 = 1), the response has `rsp_paddr` = {tentry[31:12], laddr[11:0]}, `rsp_fault` = 0, `rsp_large` = 0 and `rsp_fault_lvl` = 1. Exactly two reads are made.
- R5: If the captured large-page enable is 1 and the present directory entry has bit 7 set, exactly one read is made. The response then has `rsp_paddr` = {dentry[31:22], laddr[21:0]}, `rsp_large` = 1, `rsp_fault` = 0 and `rsp_fault_lvl` = 0.
- R6: If the captured large-page enable is 0, bit 7 of the directory entry has no effect and the walk reads a table entry as in R3 and R4.
- R7: A directory entry with bit 0 clear ends the walk after one read, whatever its bit 7. The response has `rsp_fault` = 1, `rsp_fault_lvl` = 0, `rsp_paddr` = 0 and `rsp_large` = 0.
- R8: A table entry with bit 0 clear gives `rsp_fault` = 1, `rsp_fault_lvl` = 1, `rsp_paddr` = 0 and `rsp_large` = 0, after two reads.
- R9: At most one read is in flight. `mem_valid` stays low from an accepted read until its `mem_rvalid`, and `mem_addr` holds steady while `mem_ready` is low. Read stalls and read latency do not change the result.
- R10: While `rsp_valid` is 1 and `rsp_ready` is 0, `rsp_valid`, `rsp_paddr`, `rsp_fault`, `rsp_fault_lvl` and `rsp_large` stay unchanged.
- R11: `req_ready` is 1 only when the walker is idle. A request presented during a walk is not taken and does not alter the walk in progress.
- R12: Changing `dir_base` or `large_en` after a request is accepted has no effect on that walk.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle and able to take a request |
| req_laddr | input | 32 | Linear address to translate |
| dir_base | input | 32 | Page-directory base, 4 KiB aligned (low 12 bits ignored) |
| large_en | input | 1 | Global enable for 4 MiB pages |
| mem_valid | output | 1 | Entry read request |
| mem_ready | input | 1 | Memory takes the read request |
| mem_addr | output | 32 | Byte address of the entry to read |
| mem_rdata | input | 32 | Entry returned by memory |
| mem_rvalid | input | 1 | `mem_rdata` valid for this cycle |
| rsp_valid | output | 1 | Translation result available |
| rsp_ready | input | 1 | Consumer takes the result |
| rsp_paddr | output | 32 | Physical address (0 on a fault) |
| rsp_fault | output | 1 | An entry read had its present bit clear |
| rsp_fault_lvl | output | 1 | Level of the last entry read: 0 directory, 1 table |
| rsp_large | output | 1 | Result maps a 4 MiB page |

## Verification
The bench drives a directory entry with bit 7 set both with the large-page enable on and with it off. A design that checks only one of the two flags would either skip the table read it owes or make one it must not, and the read count and offset width would show this. Non-present entries are tried at each level, one of them also carrying the size flag, to catch a walker that maps a page before it tests presence or reports the wrong level. Stalled and slow reads, a response left waiting, a competing request during a walk, and base or enable changes after acceptance each target a design that issues a second read, lets the result drift, takes a request while busy, or reads live inputs instead of captured ones.

// File: rtl/pgw_pkg.sv
package pgw_pkg;

  // Geometry of the translation
  localparam int LA_W      = 32;                 // linear and physical address width
  localparam int PG_OFF_W  = 12;                 // small page offset width
  localparam int IDX_W     = 10;                 // entries per table = 2**IDX_W
  localparam int ENT_SH    = 2;                  // log2 of entry size in bytes
  localparam int LG_OFF_W  = PG_OFF_W + IDX_W;   // large page offset width
  localparam int P_BIT     = 0;                  // present flag position
  localparam int PS_BIT    = 7;                  // page-size flag position

  typedef logic [LA_W-1:0] word_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH_PDE,
    ST_WAIT_PDE,
    ST_FETCH_PTE,
    ST_WAIT_PTE,
    ST_RESPOND
  } walk_st_e;

  // Byte address of the directory entry for a linear address
  function automatic word_t dir_entry_addr(word_t base, word_t la);
    return {base[LA_W-1:PG_OFF_W], la[LA_W-1:LG_OFF_W], {ENT_SH{1'b0}}};
  endfunction

  // Byte address of the table entry named by a directory entry
  function automatic word_t tbl_entry_addr(word_t dent, word_t la);
    return {dent[LA_W-1:PG_OFF_W], la[LG_OFF_W-1:PG_OFF_W], {ENT_SH{1'b0}}};
  endfunction

  // Physical address inside a small page
  function automatic word_t small_pa(word_t tent, word_t la);
    return {tent[LA_W-1:PG_OFF_W], la[PG_OFF_W-1:0]};
  endfunction

  // Physical address inside a large page
  function automatic word_t large_pa(word_t dent, word_t la);
    return {dent[LA_W-1:LG_OFF_W], la[LG_OFF_W-1:0]};
  endfunction

endpackage

// File: rtl/pgw_ctx.sv
// Walk context: request fields captured at acceptance, directory entry
// captured when the walk descends to the table level.
module pgw_ctx
  import pgw_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  take_req,
  input  word_t la_in,
  input  word_t base_in,
  input  logic  pse_in,
  input  logic  take_dent,
  input  word_t dent_in,
  output word_t la_q,
  output word_t base_q,
  output logic  pse_q,
  output word_t dent_q
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      la_q   <= '0;
      base_q <= '0;
      pse_q  <= 1'b0;
      dent_q <= '0;
    end else begin
      if (take_req) begin
        la_q   <= la_in;
        base_q <= base_in;
        pse_q  <= pse_in;
      end
      if (take_dent) begin
        dent_q <= dent_in;
      end
    end
  end

endmodule

// File: rtl/pgw_ctrl.sv
// Walk sequencer: one read at a time, descends only when told to.
module pgw_ctrl
  import pgw_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     req_valid,
  input  logic     mem_ready,
  input  logic     mem_rvalid,
  input  logic     go_table,
  input  logic     rsp_ready,
  output walk_st_e state
);

  walk_st_e nxt;

  always_comb begin
    nxt = state;
    unique case (state)
      ST_IDLE:      if (req_valid)  nxt = ST_FETCH_PDE;
      ST_FETCH_PDE: if (mem_ready)  nxt = ST_WAIT_PDE;
      ST_WAIT_PDE:  if (mem_rvalid) nxt = go_table ? ST_FETCH_PTE : ST_RESPOND;
      ST_FETCH_PTE: if (mem_ready)  nxt = ST_WAIT_PTE;
      ST_WAIT_PTE:  if (mem_rvalid) nxt = ST_RESPOND;
      ST_RESPOND:   if (rsp_ready)  nxt = ST_IDLE;
      default:                      nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= nxt;
  end

endmodule

// File: rtl/pgw_resp.sv
// Result register: loaded once per walk, held until the consumer takes it.
module pgw_resp #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] pa_in,
  input  logic         fault_in,
  input  logic         lvl_in,
  input  logic         large_in,
  output logic [W-1:0] pa_q,
  output logic         fault_q,
  output logic         lvl_q,
  output logic         large_q
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pa_q    <= '0;
      fault_q <= 1'b0;
      lvl_q   <= 1'b0;
      large_q <= 1'b0;
    end else if (load) begin
      pa_q    <= pa_in;
      fault_q <= fault_in;
      lvl_q   <= lvl_in;
      large_q <= large_in;
    end
  end

endmodule

// File: rtl/pgw_walker.sv
module pgw_walker
  import pgw_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic [LA_W-1:0] req_laddr,
  input  logic [LA_W-1:0] dir_base,
  input  logic            large_en,
  output logic            mem_valid,
  input  logic            mem_ready,
  output logic [LA_W-1:0] mem_addr,
  input  logic [LA_W-1:0] mem_rdata,
  input  logic            mem_rvalid,
  output logic            rsp_valid,
  input  logic            rsp_ready,
  output logic [LA_W-1:0] rsp_paddr,
  output logic            rsp_fault,
  output logic            rsp_fault_lvl,
  output logic            rsp_large
);

  walk_st_e state;
  word_t    la_q, base_q, dent_q;
  logic     pse_q;

  // Named walk events, also observed by the bound checker
  logic  req_fire;
  logic  ev_dent_back;
  logic  ev_tent_back;
  logic  ent_present;
  logic  ev_go_table;
  logic  ev_large_leaf;
  logic  ev_leaf;
  word_t leaf_pa;
  logic  unused_low;

  assign req_ready     = (state == ST_IDLE);
  assign req_fire      = req_valid && req_ready;
  assign ent_present   = mem_rdata[P_BIT];
  assign ev_dent_back  = (state == ST_WAIT_PDE) && mem_rvalid;
  assign ev_tent_back  = (state == ST_WAIT_PTE) && mem_rvalid;
  assign ev_large_leaf = ev_dent_back && ent_present && pse_q && mem_rdata[PS_BIT];
  assign ev_go_table   = ev_dent_back && ent_present && !(pse_q && mem_rdata[PS_BIT]);
  assign ev_leaf       = (ev_dent_back && !ev_go_table) || ev_tent_back;

  always_comb begin
    if (!ent_present)       leaf_pa = '0;
    else if (ev_large_leaf) leaf_pa = large_pa(mem_rdata, la_q);
    else                    leaf_pa = small_pa(mem_rdata, la_q);
  end

  assign mem_valid = (state == ST_FETCH_PDE) || (state == ST_FETCH_PTE);
  assign mem_addr  = (state == ST_FETCH_PTE) ? tbl_entry_addr(dent_q, la_q)
                                             : dir_entry_addr(base_q, la_q);
  assign rsp_valid = (state == ST_RESPOND);

  // Entry flag bits and base alignment bits that no path consumes
  assign unused_low = ^{base_q[PG_OFF_W-1:0], dent_q[PG_OFF_W-1:0]};

  pgw_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .mem_ready  (mem_ready),
    .mem_rvalid (mem_rvalid),
    .go_table   (ev_go_table),
    .rsp_ready  (rsp_ready),
    .state      (state)
  );

  pgw_ctx u_ctx (
    .clk       (clk),
    .rst_n     (rst_n),
    .take_req  (req_fire),
    .la_in     (req_laddr),
    .base_in   (dir_base),
    .pse_in    (large_en),
    .take_dent (ev_go_table),
    .dent_in   (mem_rdata),
    .la_q      (la_q),
    .base_q    (base_q),
    .pse_q     (pse_q),
    .dent_q    (dent_q)
  );

  pgw_resp #(.W(LA_W)) u_resp (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (ev_leaf),
    .pa_in    (leaf_pa),
    .fault_in (!ent_present),
    .lvl_in   (ev_tent_back),
    .large_in (ev_large_leaf),
    .pa_q     (rsp_paddr),
    .fault_q  (rsp_fault),
    .lvl_q    (rsp_fault_lvl),
    .large_q  (rsp_large)
  );

endmodule

// File: rtl/pgw_walker_chk.sv
module pgw_walker_chk
  import pgw_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic        req_ready,
  input logic        mem_valid,
  input logic        mem_ready,
  input logic [LA_W-1:0] mem_addr,
  input logic        mem_rvalid,
  input logic        rsp_valid,
  input logic        rsp_ready,
  input logic [LA_W-1:0] rsp_paddr,
  input logic        rsp_fault,
  input logic        rsp_fault_lvl,
  input logic        rsp_large,
  input logic        ev_large
);

  // Independent in-flight tracker built from the port handshakes
  logic in_flight;
  always_ff @(posedge clk) begin
    if (!rst_n)                      in_flight <= 1'b0;
    else if (mem_valid && mem_ready) in_flight <= 1'b1;
    else if (mem_rvalid)             in_flight <= 1'b0;
  end

  assert_one_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
    in_flight |-> !mem_valid);

  assert_addr_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr)));

  assert_rsp_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_paddr) && $stable(rsp_fault)
                                   && $stable(rsp_fault_lvl) && $stable(rsp_large)));

  assert_idle_only_R11: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (!mem_valid && !rsp_valid));

  assert_large_leaf_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ev_large |=> (rsp_valid && rsp_large && !rsp_fault));

  assert_fault_clean_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault) |-> (rsp_paddr == '0 && !rsp_large));

endmodule

bind pgw_walker pgw_walker_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .req_ready     (req_ready),
  .mem_valid     (mem_valid),
  .mem_ready     (mem_ready),
  .mem_addr      (mem_addr),
  .mem_rvalid    (mem_rvalid),
  .rsp_valid     (rsp_valid),
  .rsp_ready     (rsp_ready),
  .rsp_paddr     (rsp_paddr),
  .rsp_fault     (rsp_fault),
  .rsp_fault_lvl (rsp_fault_lvl),
  .rsp_large     (rsp_large),
  .ev_large      (ev_large_leaf)
);

// File: tb/pgw_walker_tb.sv
`timescale 1ns/1ps
module pgw_walker_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_laddr = '0;
  logic [31:0] dir_base = '0;
  logic        large_en = 1'b0;
  logic        mem_valid;
  logic        mem_ready = 1'b0;
  logic [31:0] mem_addr;
  logic [31:0] mem_rdata = '0;
  logic        mem_rvalid = 1'b0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b0;
  logic [31:0] rsp_paddr;
  logic        rsp_fault;
  logic        rsp_fault_lvl;
  logic        rsp_large;

  int n_chk = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  pgw_walker u_dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_laddr(req_laddr),
    .dir_base(dir_base), .large_en(large_en),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_addr(mem_addr),
    .mem_rdata(mem_rdata), .mem_rvalid(mem_rvalid),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_paddr(rsp_paddr),
    .rsp_fault(rsp_fault), .rsp_fault_lvl(rsp_fault_lvl), .rsp_large(rsp_large)
  );

  // ---------------- memory model (acts on falling edges) ----------------
  logic [31:0] mem_img [logic [31:0]];
  logic [31:0] rd_log [16];
  int          rd_cnt = 0;
  int          hold_cfg = 0;
  int          lat_cfg = 0;
  int          hold_left = 0;
  int          lat_left = 0;
  int          viol = 0;
  logic        pend = 1'b0;
  logic [31:0] pend_a = '0;

  function automatic logic [31:0] rd_word(logic [31:0] a);
    return mem_img.exists(a) ? mem_img[a] : 32'h0;
  endfunction

  always @(negedge clk) begin
    if (!rst_n) begin
      pend       <= 1'b0;
      mem_rvalid <= 1'b0;
      mem_ready  <= 1'b0;
      hold_left  <= 0;
    end else begin
      if (pend && mem_valid) viol <= viol + 1;
      mem_rvalid <= 1'b0;
      if (pend) begin
        if (lat_left == 0) begin
          mem_rvalid <= 1'b1;
          mem_rdata  <= rd_word(pend_a);
          pend       <= 1'b0;
        end else begin
          lat_left <= lat_left - 1;
        end
      end
      if (!mem_valid) begin
        hold_left <= hold_cfg;
        mem_ready <= 1'b0;
      end else if (hold_left != 0) begin
        hold_left <= hold_left - 1;
        mem_ready <= 1'b0;
      end else begin
        mem_ready <= 1'b1;
        pend      <= 1'b1;
        pend_a    <= mem_addr;
        lat_left  <= lat_cfg;
        rd_log[rd_cnt % 16] <= mem_addr;
        rd_cnt    <= rd_cnt + 1;
      end
    end
  end

  // ---------------- reference arithmetic ----------------
  function automatic logic [31:0] ref_dir(logic [31:0] base, logic [31:0] la);
    return (base & 32'hFFFF_F000) + ((la >> 22) * 4);
  endfunction
  function automatic logic [31:0] ref_tbl(logic [31:0] dent, logic [31:0] la);
    return (dent & 32'hFFFF_F000) + (((la >> 12) & 32'h3FF) * 4);
  endfunction
  function automatic logic [31:0] ref_small(logic [31:0] tent, logic [31:0] la);
    return (tent & 32'hFFFF_F000) | (la & 32'h0000_0FFF);
  endfunction
  function automatic logic [31:0] ref_large(logic [31:0] dent, logic [31:0] la);
    return (dent & 32'hFFC0_0000) | (la & 32'h003F_FFFF);
  endfunction

  // ---------------- helpers ----------------
  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%08h expected 0x%08h", tag, what, act, exp);
    end
  endtask

  // all tasks start and end just after a falling edge
  task automatic send_req(logic [31:0] la);
    req_laddr = la;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_rsp(string tag, output bit ok);
    ok = 1'b0;
    for (int i = 0; i < 400; i++) begin
      if (rsp_valid) begin
        ok = 1'b1;
        break;
      end
      @(negedge clk);
    end
    if (!ok) chk(tag, "response timeout", 32'h0, 32'h1);
  endtask

  task automatic take_rsp();
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
  endtask

  // Full walk with expectations derived from the requirements
  task automatic walk_and_check(string tag, logic [31:0] la, logic [31:0] base,
                                logic pse, logic [31:0] dent, logic [31:0] tent);
    logic [31:0] da, ta, e_pa;
    logic        e_fault, e_lvl, e_large;
    int          e_reads, c0;
    bit          ok;
    da = ref_dir(base, la);
    ta = ref_tbl(dent, la);
    mem_img[da] = dent;
    if (ta != da) mem_img[ta] = tent;
    if (!dent[0]) begin
      e_fault = 1; e_lvl = 0; e_large = 0; e_pa = 0; e_reads = 1;
    end else if (pse && dent[7]) begin
      e_fault = 0; e_lvl = 0; e_large = 1; e_pa = ref_large(dent, la); e_reads = 1;
    end else if (!tent[0]) begin
      e_fault = 1; e_lvl = 1; e_large = 0; e_pa = 0; e_reads = 2;
    end else begin
      e_fault = 0; e_lvl = 1; e_large = 0; e_pa = ref_small(tent, la); e_reads = 2;
    end
    dir_base = base;
    large_en = pse;
    c0 = rd_cnt;
    send_req(la);
    wait_rsp(tag, ok);
    if (ok) begin
      chk(tag, "paddr", rsp_paddr, e_pa);
      chk(tag, "fault", 32'(rsp_fault), 32'(e_fault));
      chk(tag, "level", 32'(rsp_fault_lvl), 32'(e_lvl));
      chk(tag, "large", 32'(rsp_large), 32'(e_large));
      chk(tag, "read count", 32'(rd_cnt - c0), 32'(e_reads));
      chk("R2", "directory read address", rd_log[c0 % 16], da);
      if (e_reads == 2) chk("R3", "table read address", rd_log[(c0 + 1) % 16], ta);
      take_rsp();
      chk(tag, "response released", 32'(rsp_valid), 32'h0);
    end
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset();
    chk("R1", "req_ready after reset", 32'(req_ready), 32'h1);
    chk("R1", "mem_valid after reset", 32'(mem_valid), 32'h0);
    chk("R1", "rsp_valid after reset", 32'(rsp_valid), 32'h0);
  endtask

  task automatic t_small();
    walk_and_check("R4", 32'h0AB4_5678, 32'h0012_3000, 1'b0, 32'h0555_6001, 32'h789A_B003);
    walk_and_check("R4", 32'hFFFF_FFFF, 32'h7FFF_F000, 1'b1, 32'h1234_5067, 32'hFEDC_B001);
    walk_and_check("R4", 32'h0000_0000, 32'h0004_0ABC, 1'b0, 32'h0020_0001, 32'h0000_1001);
  endtask

  task automatic t_large();
    walk_and_check("R5", 32'h0AB4_5678, 32'h0030_0000, 1'b1, 32'h4C00_0081, 32'h0);
    walk_and_check("R5", 32'hC03F_FFFF, 32'h0030_0000, 1'b1, 32'hFFFF_FFFF, 32'h0);
  endtask

  task automatic t_pse_off();
    walk_and_check("R6", 32'h1234_5ABC, 32'h0050_0000, 1'b0, 32'h0066_6081, 32'h0ABC_D001);
  endtask

  task automatic t_dir_miss();
    walk_and_check("R7", 32'h2000_1234, 32'h0060_0000, 1'b1, 32'h4C00_0080, 32'h0);
    walk_and_check("R7", 32'h2040_1234, 32'h0060_0000, 1'b0, 32'h0077_7FFE, 32'h0);
  endtask

  task automatic t_tbl_miss();
    walk_and_check("R8", 32'h3040_5678, 32'h0070_0000, 1'b1, 32'h0088_8001, 32'hABCD_E000);
  endtask

  task automatic t_stall();
    hold_cfg = 3;
    lat_cfg  = 4;
    walk_and_check("R9", 32'h5555_5555, 32'h0090_0000, 1'b0, 32'h00A0_0001, 32'h1357_9001);
    walk_and_check("R9", 32'h5AA5_5555, 32'h0090_0000, 1'b1, 32'hA800_0081, 32'h0);
    chk("R9", "read issued while one in flight", 32'(viol), 32'h0);
    hold_cfg = 0;
    lat_cfg  = 0;
  endtask

  task automatic t_hold();
    logic [31:0] la, pa0;
    logic        f0, l0, g0;
    bit          ok;
    la = 32'h6123_4567;
    mem_img[ref_dir(32'h00B0_0000, la)] = 32'h00C0_0001;
    mem_img[ref_tbl(32'h00C0_0001, la)] = 32'h2468_A001;
    dir_base = 32'h00B0_0000;
    large_en = 1'b0;
    send_req(la);
    wait_rsp("R10", ok);
    if (ok) begin
      pa0 = rsp_paddr; f0 = rsp_fault; l0 = rsp_fault_lvl; g0 = rsp_large;
      chk("R10", "paddr", pa0, ref_small(32'h2468_A001, la));
      for (int i = 0; i < 6; i++) begin
        @(negedge clk);
        chk("R10", "valid held", 32'(rsp_valid), 32'h1);
        chk("R10", "paddr held", rsp_paddr, pa0);
        chk("R10", "flags held", {29'h0, rsp_fault, rsp_fault_lvl, rsp_large}, {29'h0, f0, l0, g0});
      end
      take_rsp();
      chk("R10", "released after accept", 32'(rsp_valid), 32'h0);
    end
  endtask

  task automatic t_busy();
    logic [31:0] la1, la2;
    int          c0;
    bit          ok;
    la1 = 32'h7001_2345;
    la2 = 32'h0000_0ABC;
    mem_img[ref_dir(32'h00D0_0000, la1)] = 32'h00E0_0001;
    mem_img[ref_tbl(32'h00E0_0001, la1)] = 32'h3690_C001;
    lat_cfg  = 5;
    dir_base = 32'h00D0_0000;
    large_en = 1'b0;
    c0 = rd_cnt;
    send_req(la1);
    req_laddr = la2;
    req_valid = 1'b1;
    for (int i = 0; i < 4; i++) begin
      chk("R11", "ready low during walk", 32'(req_ready), 32'h0);
      @(negedge clk);
    end
    req_valid = 1'b0;
    wait_rsp("R11", ok);
    if (ok) begin
      chk("R11", "result of first request", rsp_paddr, ref_small(32'h3690_C001, la1));
      chk("R11", "reads for one walk", 32'(rd_cnt - c0), 32'h2);
      take_rsp();
      repeat (4) @(negedge clk);
      chk("R11", "no extra walk started", 32'(rd_cnt - c0), 32'h2);
    end
    lat_cfg = 0;
  endtask

  task automatic t_sample();
    logic [31:0] la, dent;
    int          c0;
    bit          ok;
    la   = 32'h8123_4567;
    dent = 32'h9C00_0081;
    mem_img[ref_dir(32'h00F0_0000, la)] = dent;
    hold_cfg = 2;
    dir_base = 32'h00F0_0000;
    large_en = 1'b1;
    c0 = rd_cnt;
    send_req(la);
    dir_base = 32'h0111_0000;
    large_en = 1'b0;
    wait_rsp("R12", ok);
    if (ok) begin
      chk("R12", "directory read uses captured base", rd_log[c0 % 16], ref_dir(32'h00F0_0000, la));
      chk("R12", "large enable captured", 32'(rsp_large), 32'h1);
      chk("R12", "paddr", rsp_paddr, ref_large(dent, la));
      chk("R12", "single read", 32'(rd_cnt - c0), 32'h1);
      take_rsp();
    end
    hold_cfg = 0;
  endtask

  // ---------------- main ----------------
  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_small();
    t_large();
    t_pse_off();
    t_dir_miss();
    t_tbl_miss();
    t_stall();
    t_hold();
    t_busy();
    t_sample();
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual running expected finished");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

endmodule